// File: doc/BRIEF.md
# Stored-Edge PWM Waveform Player

This block produces a two-level excitation waveform by replaying a small table of switching instants. A free-running period counter runs from zero to the last count of one carrier period. Each table entry holds the count, within that period, at which the output must change level. The entry in use sits in a compare register. When the counter reaches it, the output flips and the following entry is loaded into the compare register, with no processor involvement. At the end of every period the output is driven low and replay restarts from the first entry. The level at each period start is therefore known, whatever happened before.

The block also gives a one-cycle reference pulse at each period start. It gives a sample strobe several times per period, shifted by a programmable phase so that downstream converters can line up with the waveform. The table is loaded through a simple write port while the block is disabled. Raising the enable starts replay from count zero and entry zero. With the defaults (a 15000-cycle period at 150 MHz, so 10 kHz), 42 switching instants and four strobes per period are used.

Top module: `stored_edge_pwm`

## Requirements
- R1: While reset is high, or while `en` is low, `pwm_out`, `ref_pulse` and `smp_strobe` are all 0.
- R2: The period counter is 0 in the first cycle in which `en` is high. It advances by one each enabled cycle and returns to 0 after PERIOD-1, so a period lasts PERIOD cycles (15000 by default). Each new enable restarts it at 0.
- R3: Entries are used in index order from entry 0 in each period. In the enabled cycle where the counter equals the entry in use, `pwm_out` flips at the closing clock edge, so the new level is visible in the following cycle.
- R4: At the closing edge of the cycle with count PERIOD-1, `pwm_out` goes to 0. This holds even if the entry in use also equals PERIOD-1, in which case the toggle is discarded.
- R5: Entries not reached by the end of a period are skipped, including values of PERIOD or more. The next period starts again with entry 0.
- R6: `ref_pulse` is 1 for exactly one cycle per period: the cycle after the counter held 0 while enabled.
- R7: With Q = PERIOD/STROBES (3750 by default), `smp_strobe` is 1 in the cycle after each enabled count c with c mod Q equal to `phase_dly`. For `phase_dly` < Q this gives STROBES one-cycle pulses per period.
- R8: A table write (`tbl_we` high, entry `tbl_addr`, value `tbl_data`) takes effect only when `en` is low. A write while enabled leaves the stored table, and hence the waveform, unchanged.
- R9: When `en` falls, all three outputs are 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; rising restarts the period |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table entry index |
| tbl_data | input | 14 | Switching instant in clock counts |
| phase_dly | input | 14 | Strobe offset in counts within each strobe interval |
| pwm_out | output | 1 | Two-level excitation output |
| ref_pulse | output | 1 | Period-start reference pulse |
| smp_strobe | output | 1 | Delayed sample strobe |

## Verification
The end-of-period forcing of the output to low and a stored switching instant can fall on the same count. That is, the last counter value PERIOD-1 can also be the current entry. A second table provokes this by placing an entry at PERIOD-1 after an even number of earlier toggles, so that a toggle alone would drive the output high there. The case is judged by requiring the output to read low in the cycle after that count. The table then goes on with an entry that can never be reached. This shows that replay of the next period starts again at entry 0 and does not wait on the stale entry.

// File: rtl/sep_pkg.sv
`timescale 1ns/1ps
package sep_pkg;
  localparam int DEF_PERIOD  = 15000;
  localparam int DEF_EDGES   = 42;
  localparam int DEF_STROBES = 4;

  function automatic int bits_for(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sep_period_timer.sv
`timescale 1ns/1ps
module sep_period_timer #(
  parameter int PERIOD = 15000,
  parameter int CW     = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          ref_pulse
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  assign wrap = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= en && (cnt == '0);
      if (!en || wrap) cnt <= '0;
      else             cnt <= cnt + CW'(1);
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R6
  ref_single_chk: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse);
endmodule

// File: rtl/sep_edge_table.sv
`timescale 1ns/1ps
module sep_edge_table #(
  parameter int DEPTH = 42,
  parameter int AW    = 6,
  parameter int DW    = 14
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sep_edge_seq.sv
`timescale 1ns/1ps
module sep_edge_seq #(
  parameter int EDGES = 42,
  parameter int AW    = 6,
  parameter int CW    = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic          wrap,
  input  logic [CW-1:0] cmp,
  output logic [AW-1:0] raddr,
  output logic          pwm_out
);
  localparam logic [AW-1:0] LAST_IDX = AW'(EDGES - 1);

  logic [AW-1:0] ptr;
  logic          done;
  logic          match;
  logic          at_last;

  assign at_last = (ptr == LAST_IDX);
  assign match   = en && !done && (cnt == cmp);

  always_comb begin
    if (!en || wrap)          raddr = '0;
    else if (match && at_last) raddr = '0;
    else if (match)           raddr = ptr + AW'(1);
    else                      raddr = ptr;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ptr     <= '0;
      done    <= 1'b0;
      pwm_out <= 1'b0;
    end else if (wrap) begin
      ptr     <= '0;
      done    <= 1'b0;
      pwm_out <= 1'b0;
    end else if (match) begin
      pwm_out <= ~pwm_out;
      if (at_last) done <= 1'b1;
      else         ptr  <= ptr + AW'(1);
    end
  end

  // R4
  wrap_low_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !pwm_out);

  // R5
  wrap_restart_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (ptr == '0) && !done);

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST_IDX);
endmodule

// File: rtl/sep_strobe_gen.sv
`timescale 1ns/1ps
module sep_strobe_gen #(
  parameter int PERIOD  = 15000,
  parameter int STROBES = 4,
  parameter int CW      = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] phase_dly,
  output logic          strobe
);
  localparam int QUARTER = PERIOD / STROBES;
  localparam logic [CW-1:0] QLAST = CW'(QUARTER - 1);

  logic [CW-1:0] qcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      qcnt   <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= en && (qcnt == phase_dly);
      if (!en || qcnt == QLAST) qcnt <= '0;
      else                      qcnt <= qcnt + CW'(1);
    end
  end

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && QUARTER > 1) |=> !strobe);
endmodule

// File: rtl/stored_edge_pwm.sv
`timescale 1ns/1ps
module stored_edge_pwm #(
  parameter int PERIOD  = sep_pkg::DEF_PERIOD,
  parameter int EDGES   = sep_pkg::DEF_EDGES,
  parameter int STROBES = sep_pkg::DEF_STROBES,
  parameter int CW      = sep_pkg::bits_for(PERIOD),
  parameter int AW      = sep_pkg::bits_for(EDGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic [CW-1:0] tbl_data,
  input  logic [CW-1:0] phase_dly,
  output logic          pwm_out,
  output logic          ref_pulse,
  output logic          smp_strobe
);
  logic [CW-1:0] cnt;
  logic          wrap;
  logic [AW-1:0] raddr;
  logic [CW-1:0] cmp;
  logic          we_ok;

  assign we_ok = tbl_we && !en;

  sep_period_timer #(.PERIOD(PERIOD), .CW(CW)) u_timer (
    .clk(clk), .rst(rst), .en(en),
    .cnt(cnt), .wrap(wrap), .ref_pulse(ref_pulse)
  );

  sep_edge_table #(.DEPTH(EDGES), .AW(AW), .DW(CW)) u_table (
    .clk(clk), .we(we_ok), .waddr(tbl_addr), .wdata(tbl_data),
    .raddr(raddr), .rdata(cmp)
  );

  sep_edge_seq #(.EDGES(EDGES), .AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .en(en), .cnt(cnt), .wrap(wrap),
    .cmp(cmp), .raddr(raddr), .pwm_out(pwm_out)
  );

  sep_strobe_gen #(.PERIOD(PERIOD), .STROBES(STROBES), .CW(CW)) u_strobe (
    .clk(clk), .rst(rst), .en(en), .phase_dly(phase_dly),
    .strobe(smp_strobe)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk)
    rst |=> !pwm_out && !ref_pulse && !smp_strobe);

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out && !ref_pulse && !smp_strobe);
endmodule

// File: tb/stored_edge_pwm_test.sv
`timescale 1ns/1ps
module stored_edge_pwm_test;
  localparam int P  = 15000;
  localparam int E  = 42;
  localparam int S  = 4;
  localparam int Q  = P / S;
  localparam int NV = 4;
  // vector table: phase, table select, run length, expected strobes in first period
  localparam int VEC_PH [NV] = '{0, 1, 1874, 3749};
  localparam int VEC_TB [NV] = '{0, 0, 0, 1};
  localparam int VEC_LEN[NV] = '{P + 20, P + 20, P + 20, 2 * P};
  localparam int VEC_NS [NV] = '{S, S, S, S};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic tbl_we = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic [13:0] tbl_data = '0;
  logic [13:0] phase_dly = '0;
  logic pwm_out, ref_pulse, smp_strobe;

  int total = 0;
  int bad = 0;
  int tab[E];

  always #2 clk = ~clk;

  stored_edge_pwm uut (
    .clk(clk), .rst(rst), .en(en), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .phase_dly(phase_dly), .pwm_out(pwm_out),
    .ref_pulse(ref_pulse), .smp_strobe(smp_strobe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int entry_of(input int sel, input int i);
    if (sel == 0) return 100 + i * 350 + (i % 3) * 17;
    if (i < 40) return 50 + i * 300;
    if (i == 40) return P - 1;
    return 16000;
  endfunction

  task automatic load_table(input int sel);
    en = 1'b0;
    for (int i = 0; i < E; i++) begin
      tab[i]   = entry_of(sel, i);
      tbl_we   = 1'b1;
      tbl_addr = 6'(i);
      tbl_data = 14'(tab[i]);
      @(negedge clk);
    end
    tbl_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // starts at a negedge with en low; returns strobes seen in the first period
  task automatic run_span(input int len, input int ph, input int wr_at, output int nstb);
    int lvl = 0;
    int idx = 0;
    nstb = 0;
    phase_dly = 14'(ph);
    en = 1'b1;
    for (int k = 0; k < len; k++) begin
      if (k == wr_at) begin
        tbl_we = 1'b1; tbl_addr = 6'd2; tbl_data = 14'd7;   // R8: must be ignored
      end else begin
        tbl_we = 1'b0;
      end
      @(negedge clk);
      begin
        int c = k % P;
        if (c == P - 1) begin
          lvl = 0; idx = 0;
        end else if (idx < E && c == tab[idx]) begin
          lvl ^= 1; idx++;
        end
        if (c == P - 1)   chk("R4 forced low at period end", int'(pwm_out), lvl);
        else if (wr_at >= 0) chk("R8 toggle with write while enabled", int'(pwm_out), lvl);
        else              chk("R3 toggle on stored count", int'(pwm_out), lvl);
        chk("R6 reference pulse", int'(ref_pulse), (c == 0) ? 1 : 0);
        chk("R7 sample strobe", int'(smp_strobe), ((c % Q) == ph) ? 1 : 0);
        if (k < P && smp_strobe) nstb++;
      end
    end
    tbl_we = 1'b0;
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ns;
    // R1: reset dominates even with enable high
    en = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 pwm in reset", int'(pwm_out), 0);
    chk("R1 ref in reset", int'(ref_pulse), 0);
    chk("R1 strobe in reset", int'(smp_strobe), 0);
    rst = 1'b0;
    en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 pwm idle", int'(pwm_out), 0);
    chk("R1 strobe idle", int'(smp_strobe), 0);

    // vector walk; each new enable restarts the period (R2)
    for (int v = 0; v < NV; v++) begin
      load_table(VEC_TB[v]);
      run_span(VEC_LEN[v], VEC_PH[v], -1, ns);
      chk("R7 strobes per period", ns, VEC_NS[v]);
      // R5: second table's unreachable entry never stalls the next period (checked in run)
    end

    // R8: write during run ignored, waveform still follows the first table
    load_table(0);
    run_span(P + 10, 0, 0, ns);

    // R9 and R2: disable mid-period while the output is high
    phase_dly = 14'd0;
    en = 1'b1;
    repeat (200) @(negedge clk);
    chk("R3 level after first entry", int'(pwm_out), 1);
    en = 1'b0;
    @(negedge clk);
    chk("R9 pwm after disable", int'(pwm_out), 0);
    chk("R9 ref after disable", int'(ref_pulse), 0);
    chk("R9 strobe after disable", int'(smp_strobe), 0);
    repeat (2) @(negedge clk);

    // R2: restart after the mid-period stop aligns to count 0 again
    run_span(300, 5, -1, ns);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule